// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node controller that keeps coherence for the memory blocks it owns in a shared-memory system with a small, fixed number of nodes. For each block it holds a directory record with three fields. The first is the state: Uncached, Shared or Exclusive. The second is a bit vector with one bit per node that marks the sharers. The third is the identity of the owner, which is used when the block is Exclusive. The controller also holds the block contents in a small local store.

Nodes send requests over a valid/ready port. A request is a read miss, a write miss, an upgrade or a writeback. Nodes send their answers on a separate response port, which is always accepted. An answer is either an invalidation acknowledgement or the owner's copy of the data. The controller replies on a valid/ready message port. A reply is a data reply, an invalidate, a fetch to the current owner, or a permission grant. It handles one transaction at a time. While a transaction is open, every further request waits at the port. This makes the controller the only point that orders racing writes to the same block.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `msg_valid` is 0 and every block is Uncached. Memory word `b` holds `MEM_SEED + b`.
- R2: A read (`req_kind` 0) to an Uncached block returns a data reply (`msg_kind` 0) to the requester, carrying the stored word. The block becomes Shared, with the requester as its only sharer.
- R3: A read to a Shared block returns a data reply with the stored word and sends no invalidate. The requester is added to the sharers.
- R4: A write or upgrade to a Shared block sends an invalidate (`msg_kind` 1) to each other sharer, in ascending node order. No invalidate goes to the requester. The reply is held until the same number of acknowledgements (`rsp_kind` 0) have arrived. The block then becomes Exclusive to the requester.
- R5: An upgrade (`req_kind` 2) from a current sharer of a Shared block is answered with a grant (`msg_kind` 3). If the requester is the only sharer, the grant is sent at once, without any invalidate.
- R6: An upgrade from a node that is not a sharer is handled as a write miss and is answered with a data reply.
- R7: A write (`req_kind` 1) to an Uncached block returns a data reply with the stored word. The block becomes Exclusive to the requester.
- R8: A read to an Exclusive block sends a fetch (`msg_kind` 2) to the owner. When the owner's data (`rsp_kind` 1) arrives, it is written to memory and forwarded to the requester. The block becomes Shared, with the old owner and the requester as sharers.
- R9: A write to an Exclusive block sends a fetch to the owner. The owner's data is written to memory and forwarded to the requester, which becomes the new owner. The block stays Exclusive.
- R10: A writeback (`req_kind` 3) from the owner of an Exclusive block writes its data to memory and makes the block Uncached. No message is sent.
- R11: A writeback from any node that is not the owner of an Exclusive block has no effect.
- R12: `req_ready` stays 0 from the acceptance of a non-writeback request until that transaction's reply is taken. Requests that were held are then served in the order they are accepted. A second write to the same block therefore finds the first writer as owner.
- R13: While `msg_valid` is 1 and `msg_ready` is 0, the message and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 2 | 0 read, 1 write, 2 upgrade, 3 writeback |
| req_node | input | NODE_W | Requesting node |
| req_blk | input | ADDR_W | Block index |
| req_wdata | input | DATA_W | Writeback data |
| rsp_valid | input | 1 | Node response present (always taken) |
| rsp_kind | input | 1 | 0 invalidation ack, 1 owner data |
| rsp_node | input | NODE_W | Responding node |
| rsp_data | input | DATA_W | Owner data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 2 | 0 data, 1 invalidate, 2 fetch, 3 grant |
| msg_node | output | NODE_W | Destination node |
| msg_blk | output | ADDR_W | Block index |
| msg_data | output | DATA_W | Data for data replies, zero otherwise |

## Verification
The hardest situation to reach is two writes racing for the same block. The second write must stay at the port while the first is waiting for its owner's data. After that, the second write must be sent to the first writer as the new owner. The bench reaches this by opening a fetch transaction and then, in a parallel thread, holding a second write to the same block. It confirms that `req_ready` stays low, returns the owner data, and then expects a fetch addressed to the first writer. The bench also reaches partial acknowledgement by holding back one of two acknowledgements and checking that no reply appears.

// File: rtl/home_pkg.sv
package home_pkg;

    typedef enum logic [1:0] {
        DIR_UNC = 2'd0,
        DIR_SHR = 2'd1,
        DIR_EXC = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        REQ_READ  = 2'd0,
        REQ_WRITE = 2'd1,
        REQ_UPGR  = 2'd2,
        REQ_WBACK = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        MSG_DATA  = 2'd0,
        MSG_INV   = 2'd1,
        MSG_FETCH = 2'd2,
        MSG_GRANT = 2'd3
    } msg_kind_e;

    localparam logic RSP_ACK  = 1'b0;
    localparam logic RSP_DATA = 1'b1;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_INV      = 3'd1,
        ST_FETCH    = 3'd2,
        ST_WAIT_OWN = 3'd3,
        ST_REPLY    = 3'd4
    } ctl_state_e;

endpackage

// File: rtl/home_low_pick.sv
module home_low_pick #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/home_mem_store.sv
module home_mem_store #(
    parameter int          N_BLOCKS = 8,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] MEM_SEED = 32'h1000_0000,
    localparam int         ADDR_W   = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] words [N_BLOCKS];

    for (genvar b = 0; b < N_BLOCKS; b++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= DATA_W'(MEM_SEED + 32'(b));
            end else if (wr_en && wr_addr == ADDR_W'(b)) begin
                word_q <= wr_data;
            end
        end
        assign words[b] = word_q;
    end

    assign rd_data = words[rd_addr];
endmodule

// File: rtl/home_dir_table.sv
module home_dir_table
    import home_pkg::*;
#(
    parameter int  N_NODES  = 4,
    parameter int  N_BLOCKS = 8,
    localparam int NODE_W   = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int ADDR_W   = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  rd_addr,
    output dir_state_e         rd_state,
    output logic [N_NODES-1:0] rd_sharers,
    output logic [NODE_W-1:0]  rd_owner,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  dir_state_e         wr_state,
    input  logic [N_NODES-1:0] wr_sharers,
    input  logic [NODE_W-1:0]  wr_owner
);
    dir_state_e         st_q  [N_BLOCKS];
    logic [N_NODES-1:0] shr_q [N_BLOCKS];
    logic [NODE_W-1:0]  own_q [N_BLOCKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BLOCKS; b++) begin
                st_q[b]  <= DIR_UNC;
                shr_q[b] <= '0;
                own_q[b] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_addr]  <= wr_state;
            shr_q[wr_addr] <= wr_sharers;
            own_q[wr_addr] <= wr_owner;
        end
    end

    assign rd_state   = st_q[rd_addr];
    assign rd_sharers = shr_q[rd_addr];
    assign rd_owner   = own_q[rd_addr];

    AST_SHARED_HAS_SHARER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == DIR_SHR) |-> (wr_sharers != '0)); // R3
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
    import home_pkg::*;
#(
    parameter int          N_NODES  = 4,
    parameter int          N_BLOCKS = 8,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] MEM_SEED = 32'h1000_0000,
    localparam int         NODE_W   = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int         ADDR_W   = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [NODE_W-1:0] req_node,
    input  logic [ADDR_W-1:0] req_blk,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_kind,
    input  logic [NODE_W-1:0] rsp_node,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_kind,
    output logic [NODE_W-1:0] msg_node,
    output logic [ADDR_W-1:0] msg_blk,
    output logic [DATA_W-1:0] msg_data
);
    localparam int CNT_W = NODE_W + 1;

    typedef struct packed {
        ctl_state_e         fsm;
        logic [NODE_W-1:0]  src;
        logic [ADDR_W-1:0]  blk;
        msg_kind_e          reply;
        logic [DATA_W-1:0]  rdata;
        logic [N_NODES-1:0] pend;
        logic [CNT_W-1:0]   acks;
        logic [NODE_W-1:0]  fown;
        dir_state_e         nstate;
        logic [N_NODES-1:0] nshr;
        logic [NODE_W-1:0]  nown;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // directory table and memory store wiring
    dir_state_e         tb_rd_state;
    logic [N_NODES-1:0] tb_rd_shr;
    logic [NODE_W-1:0]  tb_rd_own;
    logic               tb_we;
    logic [ADDR_W-1:0]  tb_wa;
    dir_state_e         tb_wst;
    logic [N_NODES-1:0] tb_wshr;
    logic [NODE_W-1:0]  tb_wown;
    logic [DATA_W-1:0]  mem_rdata;
    logic               mem_we;
    logic [ADDR_W-1:0]  mem_wa;
    logic [DATA_W-1:0]  mem_wd;
    logic [NODE_W-1:0]  inv_idx;
    logic               inv_any;

    home_dir_table #(.N_NODES(N_NODES), .N_BLOCKS(N_BLOCKS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (req_blk),
        .rd_state   (tb_rd_state),
        .rd_sharers (tb_rd_shr),
        .rd_owner   (tb_rd_own),
        .wr_en      (tb_we),
        .wr_addr    (tb_wa),
        .wr_state   (tb_wst),
        .wr_sharers (tb_wshr),
        .wr_owner   (tb_wown)
    );

    home_mem_store #(.N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W), .MEM_SEED(MEM_SEED)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (req_blk),
        .rd_data (mem_rdata),
        .wr_en   (mem_we),
        .wr_addr (mem_wa),
        .wr_data (mem_wd)
    );

    home_low_pick #(.N(N_NODES)) u_pick (
        .vec   (ctl_q.pend),
        .idx   (inv_idx),
        .found (inv_any)
    );

    logic [N_NODES-1:0] src_bit;
    logic [N_NODES-1:0] own_bit;
    logic [N_NODES-1:0] others;
    logic [CNT_W-1:0]   others_cnt;
    logic               accept;
    logic               upg_ok;

    always_comb begin
        src_bit = '0;
        src_bit[req_node] = 1'b1;
        own_bit = '0;
        own_bit[tb_rd_own] = 1'b1;
        others  = tb_rd_shr & ~src_bit;
        others_cnt = '0;
        for (int i = 0; i < N_NODES; i++) begin
            others_cnt = others_cnt + CNT_W'(others[i]);
        end
        accept = req_valid && (ctl_q.fsm == ST_IDLE);
        upg_ok = (req_kind == REQ_UPGR) && (tb_rd_state == DIR_SHR) && tb_rd_shr[req_node];
    end

    always_comb begin
        ctl_d   = ctl_q;
        tb_we   = 1'b0;
        tb_wa   = ctl_q.blk;
        tb_wst  = ctl_q.nstate;
        tb_wshr = ctl_q.nshr;
        tb_wown = ctl_q.nown;
        mem_we  = 1'b0;
        mem_wa  = ctl_q.blk;
        mem_wd  = rsp_data;

        unique case (ctl_q.fsm)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.src   = req_node;
                    ctl_d.blk   = req_blk;
                    ctl_d.rdata = mem_rdata;
                    ctl_d.fown  = tb_rd_own;
                    ctl_d.pend  = '0;
                    ctl_d.acks  = '0;
                    ctl_d.reply = MSG_DATA;
                    ctl_d.nown  = '0;
                    if (req_kind == REQ_READ) begin
                        ctl_d.nstate = DIR_SHR;
                        unique case (tb_rd_state)
                            DIR_SHR: begin
                                ctl_d.nshr = tb_rd_shr | src_bit;
                                ctl_d.fsm  = ST_REPLY;
                            end
                            DIR_EXC: begin
                                ctl_d.nshr = src_bit | own_bit;
                                ctl_d.fsm  = ST_FETCH;
                            end
                            default: begin
                                ctl_d.nshr = src_bit;
                                ctl_d.fsm  = ST_REPLY;
                            end
                        endcase
                    end else if (req_kind == REQ_WBACK) begin
                        if (tb_rd_state == DIR_EXC && tb_rd_own == req_node) begin
                            mem_we  = 1'b1;
                            mem_wa  = req_blk;
                            mem_wd  = req_wdata;
                            tb_we   = 1'b1;
                            tb_wa   = req_blk;
                            tb_wst  = DIR_UNC;
                            tb_wshr = '0;
                            tb_wown = '0;
                        end
                    end else begin
                        ctl_d.reply  = upg_ok ? MSG_GRANT : MSG_DATA;
                        ctl_d.nstate = DIR_EXC;
                        ctl_d.nshr   = '0;
                        ctl_d.nown   = req_node;
                        unique case (tb_rd_state)
                            DIR_SHR: begin
                                ctl_d.pend = others;
                                ctl_d.acks = others_cnt;
                                ctl_d.fsm  = (others == '0) ? ST_REPLY : ST_INV;
                            end
                            DIR_EXC: ctl_d.fsm = ST_FETCH;
                            default: ctl_d.fsm = ST_REPLY;
                        endcase
                    end
                end
            end
            ST_INV: begin
                if (msg_ready && inv_any) begin
                    ctl_d.pend[inv_idx] = 1'b0;
                end
                if (rsp_valid && rsp_kind == RSP_ACK && ctl_q.acks != '0) begin
                    ctl_d.acks = ctl_q.acks - CNT_W'(1);
                end
                if (ctl_q.pend == '0 && ctl_q.acks == '0) begin
                    ctl_d.fsm = ST_REPLY;
                end
            end
            ST_FETCH: begin
                if (msg_ready) begin
                    ctl_d.fsm = ST_WAIT_OWN;
                end
            end
            ST_WAIT_OWN: begin
                if (rsp_valid && rsp_kind == RSP_DATA && rsp_node == ctl_q.fown) begin
                    mem_we      = 1'b1;
                    ctl_d.rdata = rsp_data;
                    ctl_d.fsm   = ST_REPLY;
                end
            end
            ST_REPLY: begin
                if (msg_ready) begin
                    tb_we     = 1'b1;
                    ctl_d.fsm = ST_IDLE;
                end
            end
            default: ctl_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.fsm == ST_IDLE);

    always_comb begin
        msg_valid = 1'b0;
        msg_kind  = MSG_DATA;
        msg_node  = ctl_q.src;
        msg_data  = '0;
        unique case (ctl_q.fsm)
            ST_INV: begin
                msg_valid = inv_any;
                msg_kind  = MSG_INV;
                msg_node  = inv_idx;
            end
            ST_FETCH: begin
                msg_valid = 1'b1;
                msg_kind  = MSG_FETCH;
                msg_node  = ctl_q.fown;
            end
            ST_REPLY: begin
                msg_valid = 1'b1;
                msg_kind  = ctl_q.reply;
                msg_data  = (ctl_q.reply == MSG_DATA) ? ctl_q.rdata : '0;
            end
            default: ;
        endcase
    end
    assign msg_blk = ctl_q.blk;

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_node)
                                       && $stable(msg_data) && $stable(msg_blk))); // R13
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind != REQ_WBACK) |=> !req_ready); // R12
    AST_INV_NOT_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_INV) |-> (msg_node != ctl_q.src)); // R4
    AST_GRANT_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_GRANT) |-> (ctl_q.acks == '0 && ctl_q.pend == '0)); // R5
    AST_ACK_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RSP_ACK) |-> (ctl_q.fsm == ST_INV && ctl_q.acks != '0)); // R4
    AST_FETCH_OWNER_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_FETCH) |=> (ctl_q.fsm == ST_FETCH || ctl_q.fsm == ST_WAIT_OWN)); // R8
endmodule

// File: tb/home_dir_ctrl_bench.sv
`timescale 1ns/1ps
module home_dir_ctrl_bench;
    localparam int          NN   = 4;
    localparam int          NB   = 8;
    localparam int          DW   = 32;
    localparam logic [31:0] SEED = 32'h1000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [1:0]    req_node = '0;
    logic [2:0]    req_blk = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid = 1'b0;
    logic          rsp_kind = 1'b0;
    logic [1:0]    rsp_node = '0;
    logic [DW-1:0] rsp_data = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [1:0]    msg_kind;
    logic [1:0]    msg_node;
    logic [2:0]    msg_blk;
    logic [DW-1:0] msg_data;

    always #2.5 clk = ~clk;

    home_dir_ctrl #(.N_NODES(NN), .N_BLOCKS(NB), .DATA_W(DW), .MEM_SEED(SEED)) u_home_dir_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_node(req_node), .req_blk(req_blk), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_node(rsp_node), .rsp_data(rsp_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_node(msg_node), .msg_blk(msg_blk), .msg_data(msg_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0]    log_k [256];
    logic [1:0]    log_n_node [256];
    logic [DW-1:0] log_d [256];
    int log_n = 0;
    int rd_p = 0;

    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready && log_n < 256) begin
            log_k[log_n]      = msg_kind;
            log_n_node[log_n] = msg_node;
            log_d[log_n]      = msg_data;
            log_n++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_req(input logic [1:0] k, input logic [1:0] n, input logic [2:0] b, input logic [DW-1:0] wd);
        @(posedge clk) #1;
        req_valid = 1'b1; req_kind = k; req_node = n; req_blk = b; req_wdata = wd;
        do @(negedge clk); while (!req_ready);
        @(posedge clk) #1;
        req_valid = 1'b0;
    endtask

    task automatic send_rsp(input logic k, input logic [1:0] n, input logic [DW-1:0] d);
        @(posedge clk) #1;
        rsp_valid = 1'b1; rsp_kind = k; rsp_node = n; rsp_data = d;
        @(posedge clk) #1;
        rsp_valid = 1'b0;
    endtask

    task automatic expect_msg(input logic [1:0] k, input logic [1:0] n, input bit cd,
                              input logic [DW-1:0] d, input string tag);
        int t = 0;
        while (log_n <= rd_p && t < 100) begin
            @(negedge clk);
            t++;
        end
        if (log_n <= rd_p) begin
            check(1'b0, {tag, " no message"}, 32'(log_n), 32'(rd_p + 1));
        end else begin
            check(log_k[rd_p] == k, {tag, " kind"}, 32'(log_k[rd_p]), 32'(k));
            check(log_n_node[rd_p] == n, {tag, " node"}, 32'(log_n_node[rd_p]), 32'(n));
            if (cd) check(log_d[rd_p] == d, {tag, " data"}, log_d[rd_p], d);
            rd_p++;
        end
    endtask

    task automatic expect_quiet(input int cyc, input string tag);
        repeat (cyc) @(negedge clk);
        check(log_n == rd_p, {tag, " unexpected message"}, 32'(log_n - rd_p), 32'd0);
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
        check(msg_valid == 1'b0, "R1 msg_valid", 32'(msg_valid), 32'd0);
    endtask

    // R2 R3 R5 R4: two readers then an upgrade that must invalidate
    task automatic t_share_upgrade();
        send_req(2'd0, 2'd0, 3'd1, '0);
        expect_msg(2'd0, 2'd0, 1'b1, SEED + 32'd1, "R2 read uncached");
        send_req(2'd0, 2'd1, 3'd1, '0);
        expect_msg(2'd0, 2'd1, 1'b1, SEED + 32'd1, "R3 read shared");
        send_req(2'd2, 2'd1, 3'd1, '0);
        expect_msg(2'd1, 2'd0, 1'b0, '0, "R4 invalidate sharer");
        expect_quiet(5, "R4 grant before ack");
        send_rsp(1'b0, 2'd0, '0);
        expect_msg(2'd3, 2'd1, 1'b0, '0, "R5 grant after ack");
    endtask

    // R9 R8: ownership moves, then a reader pulls data back
    task automatic t_owner_paths();
        send_req(2'd1, 2'd2, 3'd1, '0);
        expect_msg(2'd2, 2'd1, 1'b0, '0, "R9 fetch owner");
        send_rsp(1'b1, 2'd1, 32'hBEEF);
        expect_msg(2'd0, 2'd2, 1'b1, 32'hBEEF, "R9 forward data");
        send_req(2'd0, 2'd3, 3'd1, '0);
        expect_msg(2'd2, 2'd2, 1'b0, '0, "R8 fetch owner");
        send_rsp(1'b1, 2'd2, 32'hCAFE);
        expect_msg(2'd0, 2'd3, 1'b1, 32'hCAFE, "R8 forward data");
        send_req(2'd0, 2'd0, 3'd1, '0);
        expect_msg(2'd0, 2'd0, 1'b1, 32'hCAFE, "R8 memory written");
    endtask

    // R4: write with two other sharers, acks arrive one at a time
    task automatic t_two_acks();
        send_req(2'd1, 2'd0, 3'd1, '0);
        expect_msg(2'd1, 2'd2, 1'b0, '0, "R4 first invalidate");
        expect_msg(2'd1, 2'd3, 1'b0, '0, "R4 second invalidate");
        send_rsp(1'b0, 2'd2, '0);
        expect_quiet(4, "R4 one ack pending");
        send_rsp(1'b0, 2'd3, '0);
        expect_msg(2'd0, 2'd0, 1'b1, 32'hCAFE, "R4 write data after acks");
    endtask

    // R11 R6 R10 R5
    task automatic t_writebacks();
        send_req(2'd3, 2'd1, 3'd1, 32'h1111);
        expect_quiet(3, "R11 stale writeback silent");
        send_req(2'd0, 2'd2, 3'd1, '0);
        expect_msg(2'd2, 2'd0, 1'b0, '0, "R11 owner unchanged");
        send_rsp(1'b1, 2'd0, 32'h2222);
        expect_msg(2'd0, 2'd2, 1'b1, 32'h2222, "R11 data after stale writeback");
        send_req(2'd2, 2'd3, 3'd1, '0);
        expect_msg(2'd1, 2'd0, 1'b0, '0, "R6 invalidate node0");
        expect_msg(2'd1, 2'd2, 1'b0, '0, "R6 invalidate node2");
        send_rsp(1'b0, 2'd0, '0);
        send_rsp(1'b0, 2'd2, '0);
        expect_msg(2'd0, 2'd3, 1'b1, 32'h2222, "R6 upgrade gets data");
        send_req(2'd3, 2'd3, 3'd1, 32'h3333);
        expect_quiet(3, "R10 writeback silent");
        send_req(2'd0, 2'd1, 3'd1, '0);
        expect_msg(2'd0, 2'd1, 1'b1, 32'h3333, "R10 uncached with written data");
        send_req(2'd2, 2'd1, 3'd1, '0);
        expect_msg(2'd3, 2'd1, 1'b0, '0, "R5 sole sharer grant");
    endtask

    // R7 R12: racing writes to one block
    task automatic t_race();
        send_req(2'd1, 2'd0, 3'd2, '0);
        expect_msg(2'd0, 2'd0, 1'b1, SEED + 32'd2, "R7 write uncached");
        send_req(2'd1, 2'd1, 3'd2, '0);
        expect_msg(2'd2, 2'd0, 1'b0, '0, "R12 fetch first owner");
        fork
            send_req(2'd1, 2'd3, 3'd2, '0);
            begin
                repeat (4) begin
                    @(negedge clk);
                    check(req_ready == 1'b0, "R12 held while busy", 32'(req_ready), 32'd0);
                end
                send_rsp(1'b1, 2'd0, 32'hAAAA);
                expect_msg(2'd0, 2'd1, 1'b1, 32'hAAAA, "R12 first write data");
            end
        join
        expect_msg(2'd2, 2'd1, 1'b0, '0, "R12 second write fetches first writer");
        send_rsp(1'b1, 2'd1, 32'hBBBB);
        expect_msg(2'd0, 2'd3, 1'b1, 32'hBBBB, "R12 second write data");
    endtask

    // R13
    task automatic t_backpressure();
        @(posedge clk) #1;
        msg_ready = 1'b0;
        send_req(2'd0, 2'd2, 3'd3, '0);
        repeat (3) begin
            @(negedge clk);
            check(msg_valid == 1'b1 && msg_kind == 2'd0 && msg_data == SEED + 32'd3,
                  "R13 held message", msg_data, SEED + 32'd3);
        end
        @(posedge clk) #1;
        msg_ready = 1'b1;
        expect_msg(2'd0, 2'd2, 1'b1, SEED + 32'd3, "R13 delivered");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_share_upgrade();
        t_owner_paths();
        t_two_acks();
        t_writebacks();
        t_race();
        t_backpressure();
        expect_quiet(3, "R12 no stray messages");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule